// File: doc/BRIEF.md
# Flash Operation Buffer Sequencer

This block keeps a small program of flash write and wait operations in an internal byte buffer and replays it on request. A serial command front end hands it one decoded command at a time. The commands are: empty the buffer, append a single-byte write, append a multi-byte write whose payload follows on a byte stream, append a microsecond wait, and run the buffer. Every command is answered by a one-cycle response that either accepts or refuses it.

Appended operations are stored as compact byte records. The first byte of each record is the command code, and multi-byte fields follow it least significant byte first. A single write costs 5 bytes, a wait costs 5 bytes, and a block write costs 7 bytes plus its payload. When the buffer is run, the records are decoded in the order they were stored. Writes go out on a flash write port that uses an address, a data byte, a strobe and a ready handshake. Waits count pulses of a 1 µs tick. The flash side must lower ready within one cycle after it sees the strobe.

Top module: `flash_opbuf_seq`

## Requirements
- R1: Command 0x0B empties the buffer and is accepted; a following run issues no flash strobe.
- R2: Command 0x0C (address from `cmd_addr`, data from `cmd_arg[7:0]`) takes 5 buffer bytes. When the buffer is run, it produces one strobe carrying that address and data.
- R3: Command 0x0D (length from `cmd_arg[23:0]`, start address from `cmd_addr`, payload taken from the data stream) takes 7+n buffer bytes. When the buffer is run, it strobes each payload byte in order at consecutive addresses, and address carries propagate across all 24 bits.
- R4: Command 0x0E (count from `cmd_arg`) stops the run until that many `us_tick` pulses have been seen. A count of zero moves straight on to the next record.
- R5: Command 0x0F runs the stored records in the order they were appended and is accepted when the run ends.
- R6: After a run the buffer is empty, so an immediate second run issues no strobe.
- R7: An append that would push the contents past `DEPTH` bytes is refused and does not change what is already stored. Filling the buffer to exactly `DEPTH` bytes is accepted.
- R8: `buf_size` reports `DEPTH` and `max_block` reports `DEPTH-7`.
- R9: Any command code other than 0x0B to 0x0F is refused.
- R10: The block raises `fl_we` only while `fl_ready` is high, and for one cycle per written byte.
- R11: A block write with a length of zero is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block is idle and will take a command |
| cmd_op | input | 8 | Command code |
| cmd_addr | input | 24 | Flash address for write commands |
| cmd_arg | input | 32 | Data byte, block length or microsecond count |
| dat_valid | input | 1 | Block-write payload byte present |
| dat_byte | input | 8 | Payload byte |
| dat_ready | output | 1 | Payload byte taken this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_ack | output | 1 | 1 = accepted, 0 = refused |
| fl_addr | output | 24 | Flash write address |
| fl_data | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_ready | input | 1 | Flash side can take a write |
| us_tick | input | 1 | One pulse per microsecond |
| buf_size | output | 16 | Buffer capacity in bytes |
| max_block | output | 24 | Largest accepted block-write length |

## Verification
If the fill count is wrong, an accept or refuse response comes back wrong on the very next append near the capacity edge. The same fault also makes the next run replay too many or too few strobes. If the record decoder loses its alignment, the next run shows the wrong address or data on the first strobe after the faulty record. If the wait counter is wrong, the gap between two strobes, measured in tick pulses, is off. The bench therefore fills the buffer to the exact byte and checks each strobe's address, data and tick position.

// File: rtl/flash_opbuf_seq.sv
module flash_opbuf_seq #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [7:0]  cmd_op,
  input  logic [23:0] cmd_addr,
  input  logic [31:0] cmd_arg,
  input  logic        dat_valid,
  input  logic [7:0]  dat_byte,
  output logic        dat_ready,
  output logic        rsp_valid,
  output logic        rsp_ack,
  output logic [23:0] fl_addr,
  output logic [7:0]  fl_data,
  output logic        fl_we,
  input  logic        fl_ready,
  input  logic        us_tick,
  output logic [15:0] buf_size,
  output logic [23:0] max_block
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [7:0] OP_CLR = 8'h0B, OP_ONE = 8'h0C, OP_BLK = 8'h0D,
                         OP_DLY = 8'h0E, OP_RUN = 8'h0F;

  typedef enum logic [3:0] {S_IDLE, S_HDR, S_DAT, S_XOP, S_XARG, S_XDEC, S_XWR, S_XDLY} st_t;

  st_t            st;
  logic [7:0]     mem [DEPTH];
  logic [PW-1:0]  cnt, idx;
  logic [7:0]     op;
  logic [55:0]    hdr;
  logic [2:0]     hn, k;
  logic [31:0]    rem;
  logic [23:0]    fa;
  logic [33:0]    need;
  logic           fits, mem_we;
  logic [IW-1:0]  mem_wa;
  logic [7:0]     mem_wd, rd_byte;

  assign buf_size  = 16'(DEPTH);
  assign max_block = 24'(DEPTH - 7);
  assign cmd_ready = (st == S_IDLE);
  assign dat_ready = (st == S_DAT);
  assign rd_byte   = mem[idx[IW-1:0]];
  assign need      = (cmd_op == OP_BLK) ? 34'd7 + 34'(cmd_arg[23:0]) : 34'd5;
  assign fits      = (34'(cnt) + need) <= 34'(DEPTH);
  assign mem_we    = (st == S_HDR) || (st == S_DAT && dat_valid);
  assign mem_wa    = IW'(cnt + idx);
  assign mem_wd    = (st == S_HDR) ? hdr[7:0] : dat_byte;

  always_ff @(posedge clk)
    if (mem_we) mem[mem_wa] <= mem_wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; op <= '0; hdr <= '0; hn <= '0; k <= '0;
      rem <= '0; fa <= '0; rsp_valid <= 1'b0; rsp_ack <= 1'b0;
      fl_we <= 1'b0; fl_addr <= '0; fl_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      fl_we     <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op <= cmd_op; idx <= '0;
          case (cmd_op)
            OP_CLR: begin cnt <= '0; rsp_valid <= 1'b1; rsp_ack <= 1'b1; end
            OP_RUN: st <= S_XOP;
            OP_ONE, OP_DLY: if (fits) begin
              hdr <= (cmd_op == OP_ONE) ? {16'b0, cmd_arg[7:0], cmd_addr, cmd_op}
                                        : {16'b0, cmd_arg, cmd_op};
              hn <= 3'd5; st <= S_HDR;
            end else begin rsp_valid <= 1'b1; rsp_ack <= 1'b0; end
            OP_BLK: if (fits && cmd_arg[23:0] != 24'd0) begin
              hdr <= {cmd_addr, cmd_arg[23:0], cmd_op};
              hn <= 3'd7; rem <= {8'b0, cmd_arg[23:0]}; st <= S_HDR;
            end else begin rsp_valid <= 1'b1; rsp_ack <= 1'b0; end
            default: begin rsp_valid <= 1'b1; rsp_ack <= 1'b0; end
          endcase
        end
        S_HDR: begin
          hdr <= hdr >> 8;
          idx <= idx + 1'b1;
          if (idx == PW'(hn - 3'd1)) begin
            if (op == OP_BLK) st <= S_DAT;
            else begin
              cnt <= cnt + PW'(hn); rsp_valid <= 1'b1; rsp_ack <= 1'b1; st <= S_IDLE;
            end
          end
        end
        S_DAT: if (dat_valid) begin
          idx <= idx + 1'b1;
          rem <= rem - 1'b1;
          if (rem == 32'd1) begin
            cnt <= cnt + idx + 1'b1; rsp_valid <= 1'b1; rsp_ack <= 1'b1; st <= S_IDLE;
          end
        end
        S_XOP: if (idx == cnt) begin
          cnt <= '0; rsp_valid <= 1'b1; rsp_ack <= 1'b1; st <= S_IDLE;
        end else begin
          op <= rd_byte; idx <= idx + 1'b1; k <= '0; st <= S_XARG;
        end
        S_XARG: begin
          hdr <= {rd_byte, hdr[55:8]};
          idx <= idx + 1'b1;
          k   <= k + 1'b1;
          if (k == ((op == OP_BLK) ? 3'd5 : 3'd3)) st <= S_XDEC;
        end
        S_XDEC: case (op)
          OP_ONE: begin fa <= hdr[47:24]; rem <= 32'd1; st <= S_XWR; end
          OP_BLK: begin fa <= hdr[55:32]; rem <= {8'b0, hdr[31:8]}; st <= S_XWR; end
          default: begin
            rem <= hdr[55:24];
            st  <= (hdr[55:24] == 32'd0) ? S_XOP : S_XDLY;
          end
        endcase
        S_XWR: if (fl_ready && !fl_we) begin
          fl_we   <= 1'b1;
          fl_addr <= fa;
          fl_data <= (op == OP_BLK) ? rd_byte : hdr[55:48];
          if (op == OP_BLK) idx <= idx + 1'b1;
          fa  <= fa + 1'b1;
          rem <= rem - 1'b1;
          if (rem == 32'd1) st <= S_XOP;
        end
        S_XDLY: if (us_tick) begin
          rem <= rem - 1'b1;
          if (rem == 32'd1) st <= S_XOP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_strobe_on_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> $past(fl_ready));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= PW'(DEPTH));
  p_refuse_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |-> $stable(cnt));
  p_run_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XOP && idx == cnt) |=> (cnt == '0 && rsp_valid && rsp_ack));
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !fl_we);
  p_tick_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XDLY && !us_tick) |=> $stable(rem));
endmodule

// File: tb/flash_opbuf_seq_tb.sv
module flash_opbuf_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, dat_valid = 0, us_tick = 0;
  logic [7:0] cmd_op = 0, dat_byte = 0;
  logic [23:0] cmd_addr = 0;
  logic [31:0] cmd_arg = 0;
  logic cmd_ready, dat_ready, rsp_valid, rsp_ack, fl_we;
  logic fl_ready = 1;
  logic [23:0] fl_addr, max_block;
  logic [7:0] fl_data;
  logic [15:0] buf_size;

  int n_chk = 0, n_bad = 0;
  int tick_cnt = 0, busy = 0, nwr = 0, bad_strobe = 0;
  logic [23:0] wr_a [128];
  logic [7:0]  wr_d [128];
  int          wr_t [128];
  logic [7:0]  pay [64];

  always #5 clk = ~clk;

  flash_opbuf_seq dut_i (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_arg(cmd_arg), .dat_valid(dat_valid),
    .dat_byte(dat_byte), .dat_ready(dat_ready), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .fl_addr(fl_addr), .fl_data(fl_data), .fl_we(fl_we), .fl_ready(fl_ready),
    .us_tick(us_tick), .buf_size(buf_size), .max_block(max_block));

  always @(posedge clk) begin
    if (us_tick) tick_cnt <= tick_cnt + 1;
    if (fl_we) begin
      if (!fl_ready) bad_strobe <= bad_strobe + 1;
      if (nwr < 128) begin wr_a[nwr] <= fl_addr; wr_d[nwr] <= fl_data; wr_t[nwr] <= tick_cnt; end
      nwr <= nwr + 1;
      fl_ready <= 0; busy <= 2;
    end else if (busy > 0) begin
      busy <= busy - 1;
      if (busy == 1) fl_ready <= 1;
    end
  end

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      us_tick = (c % 10 == 0);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] op, input logic [23:0] a, input logic [31:0] arg,
                        input int npay, output bit ack);
    int i = 0;
    bit hs;
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_arg = arg; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    forever begin
      if (rsp_valid) begin ack = rsp_ack; break; end
      dat_valid = (i < npay);
      dat_byte  = pay[i % 64];
      hs = dat_valid && dat_ready;
      @(negedge clk);
      if (hs) i++;
    end
    dat_valid = 0;
  endtask

  task automatic run(output bit ack);
    nwr = 0;
    do_cmd(8'h0F, 0, 0, 0, ack);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check(cmd_ready == 1, "R5 idle after reset", cmd_ready, 1);
    check(rsp_valid == 0 && fl_we == 0, "R10 quiet after reset", {rsp_valid, fl_we}, 0);
    check(buf_size == 16'd64, "R8 capacity", buf_size, 64);
    check(max_block == 24'd57, "R8 max block", max_block, 57);
  endtask

  task automatic t_single;
    bit ack;
    do_cmd(8'h0B, 0, 0, 0, ack); check(ack, "R1 init accepted", ack, 1);
    do_cmd(8'h0C, 24'hABCDEF, 32'h5A, 0, ack); check(ack, "R2 append accepted", ack, 1);
    run(ack); check(ack, "R5 run accepted", ack, 1);
    check(nwr == 1, "R2 one strobe", nwr, 1);
    check(wr_a[0] == 24'hABCDEF && wr_d[0] == 8'h5A, "R2 addr/data", {wr_a[0], wr_d[0]}, 32'hABCDEF5A);
  endtask

  task automatic t_block;
    bit ack;
    for (int j = 0; j < 4; j++) pay[j] = 8'h10 + 8'(j);
    do_cmd(8'h0D, 24'h00FFFE, 32'd4, 4, ack); check(ack, "R3 block accepted", ack, 1);
    run(ack);
    check(nwr == 4, "R3 byte count", nwr, 4);
    for (int j = 0; j < 4; j++)
      check(wr_a[j] == 24'h00FFFE + 24'(j) && wr_d[j] == 8'h10 + 8'(j), "R3 block byte",
            {wr_a[j], wr_d[j]}, {24'h00FFFE + 24'(j), 8'h10 + 8'(j)});
  endtask

  task automatic t_order;
    bit ack;
    do_cmd(8'h0C, 24'h000100, 32'hA1, 0, ack);
    do_cmd(8'h0E, 0, 32'd20, 0, ack); check(ack, "R4 delay accepted", ack, 1);
    do_cmd(8'h0C, 24'h000200, 32'hB2, 0, ack);
    do_cmd(8'h0E, 0, 32'd0, 0, ack);
    do_cmd(8'h0C, 24'h000300, 32'hC3, 0, ack);
    run(ack);
    check(nwr == 3, "R5 three strobes", nwr, 3);
    check(wr_d[0] == 8'hA1 && wr_d[1] == 8'hB2 && wr_d[2] == 8'hC3, "R5 order",
          {wr_d[0], wr_d[1], wr_d[2]}, 24'hA1B2C3);
    check(wr_t[1] - wr_t[0] >= 20 && wr_t[1] - wr_t[0] <= 22, "R4 delay of 20 ticks",
          wr_t[1] - wr_t[0], 20);
    check(wr_t[2] - wr_t[1] <= 2, "R4 zero delay", wr_t[2] - wr_t[1], 0);
  endtask

  task automatic t_empty;
    bit ack;
    run(ack); check(ack && nwr == 0, "R6 second run empty", nwr, 0);
    do_cmd(8'h0C, 24'h000400, 32'h44, 0, ack);
    do_cmd(8'h0B, 0, 0, 0, ack);
    run(ack); check(nwr == 0, "R1 init discards", nwr, 0);
  endtask

  task automatic t_overflow;
    bit ack;
    for (int j = 0; j < 12; j++) begin
      do_cmd(8'h0C, 24'(j), 32'(j + 1), 0, ack);
      check(ack, "R2 5-byte cost fits", ack, 1);
    end
    do_cmd(8'h0C, 24'h99, 32'h99, 0, ack); check(!ack, "R7 13th single refused", ack, 0);
    run(ack);
    check(nwr == 12 && wr_d[11] == 8'd12, "R7 contents kept", nwr, 12);
    for (int j = 0; j < 57; j++) pay[j] = 8'(j * 3);
    do_cmd(8'h0D, 24'h002000, 32'd57, 57, ack); check(ack, "R3 exact fill", ack, 1);
    do_cmd(8'h0E, 0, 32'd1, 0, ack); check(!ack, "R7 full refuses delay", ack, 0);
    run(ack);
    check(nwr == 57 && wr_a[56] == 24'h002038 && wr_d[56] == 8'(56 * 3), "R7 full block intact",
          {wr_a[56], wr_d[56]}, {24'h002038, 8'(56 * 3)});
    do_cmd(8'h0D, 24'h0, 32'd58, 0, ack); check(!ack, "R7 oversize block refused", ack, 0);
  endtask

  task automatic t_bad;
    bit ack;
    do_cmd(8'h42, 0, 0, 0, ack); check(!ack, "R9 unknown code", ack, 0);
    do_cmd(8'h0D, 24'h10, 32'd0, 0, ack); check(!ack, "R11 zero length", ack, 0);
    run(ack); check(nwr == 0, "R11 nothing stored", nwr, 0);
    check(bad_strobe == 0, "R10 strobe only when ready", bad_strobe, 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset; t_single; t_block; t_order; t_empty; t_overflow; t_bad;
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule